// File: doc/BRIEF.md
# USB PHY Control Register Bank with Bit-Operation Aliases

This block is the software-visible register file of a USB transceiver. It is reached over a plain word-oriented register bus: a write enable, a read enable, a byte address, four byte strobes, and 32-bit write and read data. The bank stores whatever software writes and drives no analog function. Six of its registers can be changed at four word addresses each. One address replaces the value. The other three OR in the write data, clear the bits that are set in the write data, or invert the bits that are set in the write data. Read data is registered and appears one cycle after the read request.

Bit 31 of the control register requests a soft reset. A qualifying write to control reloads four registers (power-down, transmit, receive and control) with their default values on the same clock edge. Every other register keeps its value. The debug0-status and version registers are constants. Accesses that do not cover a whole aligned word are dropped.

Top module: `usbphy_ctrl_regs`

## Requirements
- R1: After rst_ni is released, the registers read as follows: power-down (word 0x00) = 0x001E1C00, transmit (word 0x04) = 0x10060607, receive (word 0x08) = 0, control (word 0x0C) = 0xC0200000, status (word 0x10) = 0, debug (word 0x14) = 0x7F180000, debug0-status (word 0x18) = 0, debug1 (word 0x1C) = 0x00001000, version (word 0x20) = 0x04020000. The byte address is the word index times 4.
- R2: A write to the base word of power-down, transmit, receive, control, debug, debug1 or status replaces the whole register with the write data. A write to control with bit 31 high is covered by R7.
- R3: For each aliased register (bases 0x00, 0x04, 0x08, 0x0C, 0x14, 0x1C), a write to base+1 ORs the write data into the register.
- R4: A write to base+2 clears the register bits that are set in the write data.
- R5: A write to base+3 inverts the register bits that are set in the write data.
- R6: A read of any base+1, base+2 or base+3 alias returns the current value of its base register.
- R7: A write to control at base or base+1 with bit 31 of the data high loads the soft-reset values on that same edge: power-down 0x001E1C00, transmit 0x10060607, receive 0, control 0xC0200000. No other register changes.
- R8: A write to control at base+3 causes the soft reset only when bit 31 of the data is high and bit 31 of control is one after the inversion. In every other case the write is a plain inversion.
- R9: A write to control at base+2 never causes a soft reset, whatever the data.
- R10: Writes to debug0-status, version, status words 0x11 to 0x13, words 0x19 to 0x1B, and any word above 0x20 have no effect on any register.
- R11: An access is accepted only when strb_i is 4'hF and addr_i[1:0] is 0. A rejected write changes nothing. A rejected read returns zero.
- R12: rdata_o is updated only on the clock edge where re_i is high, and it holds its value otherwise. Reads of unlisted words, and of words beyond 0x20, return zero.
- R13: When a read and a write target the same address in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| we_i | input | 1 | Write request |
| re_i | input | 1 | Read request |
| addr_i | input | ADDR_W (12) | Byte address |
| strb_i | input | 4 | Byte strobes; all four must be set |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The embedded assertions assume that we_i, re_i, addr_i, strb_i and wdata_i are free of X whenever the clock rises outside reset. They also assume that a read and a write in the same cycle share one address, because the bus has only one address. The bench drives every input on the falling edge, from tasks that only ever assign known values. It limits random word indices to a range just past the version register, so every legal, unlisted and out-of-map decode is reached. It drives a partial strobe or a misaligned offset only where it is deliberately testing rejection.

// File: rtl/usbphy_regs_pkg.sv
package usbphy_regs_pkg;
  localparam int DW       = 32;
  localparam int NREG     = 9;
  localparam int SEL_W    = $clog2(NREG);
  localparam int SRST_BIT = 31;

  localparam int R_PWD   = 0;
  localparam int R_TX    = 1;
  localparam int R_RX    = 2;
  localparam int R_CTRL  = 3;
  localparam int R_STAT  = 4;
  localparam int R_DBG   = 5;
  localparam int R_DBG0S = 6;
  localparam int R_DBG1  = 7;
  localparam int R_VER   = 8;

  // bit i set: register i is storage, otherwise a constant
  localparam logic [NREG-1:0] WRITABLE  = 9'b0_1011_1111;
  localparam logic [NREG-1:0] SOFT_MASK = 9'b0_0000_1111;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } op_e;

  function automatic logic [DW-1:0] soft_value(input int idx);
    case (idx)
      R_PWD:   return 32'h001E_1C00;
      R_TX:    return 32'h1006_0607;
      R_CTRL:  return 32'hC020_0000;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] por_value(input int idx);
    case (idx)
      R_DBG:   return 32'h7F18_0000;
      R_DBG1:  return 32'h0000_1000;
      R_VER:   return 32'h0402_0000;
      R_STAT, R_DBG0S: return '0;
      default: return soft_value(idx);
    endcase
  endfunction
endpackage

// File: rtl/usbphy_addr_dec.sv
module usbphy_addr_dec
  import usbphy_regs_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] word_i,
  output logic [SEL_W-1:0] sel_o,
  output op_e              op_o,
  output logic             hit_o,
  output logic             wr_ok_o
);
  localparam int GRP_W = IDX_W - 2;

  logic [GRP_W-1:0] grp;
  logic [1:0]       sub;

  assign grp = word_i[IDX_W-1:2];
  assign sub = word_i[1:0];

  always_comb begin
    sel_o   = '0;
    op_o    = OP_WR;
    hit_o   = 1'b0;
    wr_ok_o = 1'b0;
    case (32'(grp))
      0, 1, 2, 3: begin
        sel_o   = SEL_W'(grp);
        op_o    = op_e'(sub);
        hit_o   = 1'b1;
        wr_ok_o = 1'b1;
      end
      4: if (sub == 2'd0) begin
        sel_o   = SEL_W'(R_STAT);
        hit_o   = 1'b1;
        wr_ok_o = 1'b1;
      end
      5: begin
        sel_o   = SEL_W'(R_DBG);
        op_o    = op_e'(sub);
        hit_o   = 1'b1;
        wr_ok_o = 1'b1;
      end
      6: if (sub == 2'd0) begin
        sel_o = SEL_W'(R_DBG0S);
        hit_o = 1'b1;
      end
      7: begin
        sel_o   = SEL_W'(R_DBG1);
        op_o    = op_e'(sub);
        hit_o   = 1'b1;
        wr_ok_o = 1'b1;
      end
      8: if (sub == 2'd0) begin
        sel_o = SEL_W'(R_VER);
        hit_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/usbphy_bit_op.sv
module usbphy_bit_op
  import usbphy_regs_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] nxt_o
);
  always_comb begin
    case (op_i)
      OP_SET:  nxt_o = cur_i | data_i;
      OP_CLR:  nxt_o = cur_i & ~data_i;
      OP_TOG:  nxt_o = cur_i ^ data_i;
      default: nxt_o = data_i;
    endcase
  end
endmodule

// File: rtl/usbphy_rd_mux.sv
module usbphy_rd_mux
  import usbphy_regs_pkg::*;
(
  input  logic [NREG-1:0][DW-1:0] bank_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    hit_i,
  output logic [DW-1:0]           data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_i && sel_i == SEL_W'(i)) data_o = bank_i[i];
    end
  end
endmodule

// File: rtl/usbphy_ctrl_regs.sv
module usbphy_ctrl_regs
  import usbphy_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        strb_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic                    full_word;
  logic [SEL_W-1:0]        sel;
  op_e                     op;
  logic                    hit, wr_ok, wr_fire, soft_fire;
  logic [NREG-1:0][DW-1:0] bank;
  logic [DW-1:0]           rd_val, rdata_q;

  assign full_word = (strb_i == 4'hF) && (addr_i[1:0] == 2'b00);

  usbphy_addr_dec #(.IDX_W(IDX_W)) u_dec (
    .word_i (addr_i[ADDR_W-1:2]),
    .sel_o  (sel),
    .op_o   (op),
    .hit_o  (hit),
    .wr_ok_o(wr_ok)
  );

  assign wr_fire = we_i && full_word && wr_ok;

  // toggle resets only if it leaves the bit high, i.e. bit was low before
  assign soft_fire = wr_fire && (sel == SEL_W'(R_CTRL)) && wdata_i[SRST_BIT] &&
                     ((op == OP_WR) || (op == OP_SET) ||
                      ((op == OP_TOG) && !bank[R_CTRL][SRST_BIT]));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (WRITABLE[i]) begin : g_rw
      logic [DW-1:0] q, nxt;
      logic          hit_me;

      usbphy_bit_op #(.W(DW)) u_op (
        .op_i  (op),
        .cur_i (q),
        .data_i(wdata_i),
        .nxt_o (nxt)
      );

      assign hit_me = wr_fire && (sel == SEL_W'(i));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         q <= por_value(i);
        else if (soft_fire && SOFT_MASK[i])  q <= soft_value(i);
        else if (hit_me)                     q <= nxt;
      end
      assign bank[i] = q;
    end else begin : g_ro
      assign bank[i] = por_value(i);
    end
  end

  usbphy_rd_mux u_rd (
    .bank_i(bank),
    .sel_i (sel),
    .hit_i (hit && full_word),
    .data_o(rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  // R7: set-alias write with bit 31 reloads power-down on the same edge
  assert_set_srst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && sel == SEL_W'(R_CTRL) && op == OP_SET && wdata_i[SRST_BIT])
    |=> (bank[R_PWD] == 32'h001E_1C00 && bank[R_CTRL] == 32'hC020_0000));

  // R9: clear alias on control is a pure clear
  assert_clr_ctrl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && sel == SEL_W'(R_CTRL) && op == OP_CLR)
    |=> (bank[R_CTRL] == ($past(bank[R_CTRL]) & ~$past(wdata_i))
         && $stable(bank[R_TX])));

  // R8: toggle clearing bit 31 leaves other registers untouched
  assert_tog_nosrst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && sel == SEL_W'(R_CTRL) && op == OP_TOG && bank[R_CTRL][SRST_BIT])
    |=> (bank[R_CTRL] == ($past(bank[R_CTRL]) ^ $past(wdata_i))
         && $stable(bank[R_PWD])));

  // R11: partial or misaligned write leaves the bank unchanged
  assert_reject_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !full_word) |=> $stable(bank));

  // R11: rejected read returns zero
  assert_reject_rd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !full_word) |=> (rdata_o == '0));

  // R12: read data holds without a read request
  assert_rd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  // R6: alias read returns its base register
  assert_alias_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && full_word && hit && op != OP_WR) |=> (rdata_o == $past(bank[sel])));
endmodule

// File: tb/usbphy_ctrl_regs_test.sv
`timescale 1ns/1ps
module usbphy_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  strb = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m [9];

  always #10 clk = ~clk;

  usbphy_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .strb_i(strb), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m[0] = 32'h001E1C00; m[1] = 32'h10060607; m[2] = 0; m[3] = 32'hC0200000;
    m[4] = 0; m[5] = 32'h7F180000; m[6] = 0; m[7] = 32'h00001000; m[8] = 32'h04020000;
  endtask

  task automatic model_soft();
    m[0] = 32'h001E1C00; m[1] = 32'h10060607; m[2] = 0; m[3] = 32'hC0200000;
  endtask

  // returns storage slot for an aliased group, -1 if none
  function automatic int grp_slot(int g);
    case (g)
      0, 1, 2, 3: return g;
      5: return 5;
      7: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic model_write(int w, logic [31:0] d);
    int g = w / 4, o = w % 4, r = grp_slot(w / 4);
    if (w == 16) begin m[4] = d; return; end
    if (r < 0 || g > 8) return;
    case (o)
      0: m[r] = d;
      1: m[r] = m[r] | d;
      2: m[r] = m[r] & ~d;
      default: m[r] = m[r] ^ d;
    endcase
    if (r == 3 && d[31]) begin
      if (o == 0 || o == 1) model_soft();
      else if (o == 3 && m[3][31]) model_soft();
    end
  endtask

  function automatic logic [31:0] model_read(int w);
    int r = grp_slot(w / 4);
    if (w == 16) return m[4];
    if (w == 24) return m[6];
    if (w == 32) return m[8];
    if (r >= 0 && w < 32) return m[r];
    return 32'h0;
  endfunction

  task automatic wr(int w, logic [31:0] d, logic [3:0] s = 4'hF, logic [1:0] lo = 2'b00);
    @(negedge clk);
    we = 1'b1; addr = {w[9:0], lo}; wdata = d; strb = s;
    @(negedge clk);
    we = 1'b0; strb = 4'hF;
    if (s == 4'hF && lo == 2'b00) model_write(w, d);
  endtask

  task automatic rd(string tag, int w, logic [3:0] s = 4'hF, logic [1:0] lo = 2'b00);
    logic [31:0] exp;
    exp = (s == 4'hF && lo == 2'b00) ? model_read(w) : 32'h0;
    @(negedge clk);
    re = 1'b1; addr = {w[9:0], lo}; strb = s;
    @(negedge clk);
    re = 1'b0; strb = 4'hF;
    check(tag, rdata, exp);
  endtask

  task automatic rd_all(string tag);
    int words[9] = '{0, 4, 8, 12, 16, 20, 24, 28, 32};
    foreach (words[k]) rd(tag, words[k]);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R12", rdata, 32'h0);
    rd_all("R1");

    // R2 base writes
    wr(0, 32'h12345678); wr(4, 32'hA5A5A5A5); wr(8, 32'h0F0F0F0F);
    wr(12, 32'h00000011); wr(16, 32'hDEADBEEF); wr(20, 32'h01010101); wr(28, 32'h7);
    rd_all("R2");
    // R3 set, R4 clear, R5 toggle, R6 alias reads
    wr(1, 32'h80000001); rd("R3", 0);
    wr(6, 32'h000000FF); rd("R4", 4);
    wr(31, 32'hFFFF0000); rd("R5", 28);
    wr(23, 32'h0000F000); rd("R5", 20);
    rd("R6", 1); rd("R6", 2); rd("R6", 3); rd("R6", 29); rd("R6", 15);
    // R7 set alias with bit 31
    wr(13, 32'h80000004); rd_all("R7");
    wr(8, 32'h55); wr(12, 32'h80000000); rd_all("R7");
    // R8 toggle: ctrl bit31 is 1 now -> clear, no reset
    wr(8, 32'h66);
    wr(15, 32'h80000000); rd("R8", 12); rd("R8", 8);
    // toggle again -> bit goes high -> reset
    wr(15, 32'h80000000); rd("R8", 12); rd("R8", 8);
    // toggle without bit 31 data
    wr(8, 32'h77); wr(15, 32'h00000003); rd("R8", 12); rd("R8", 8);
    // R9 clear never resets
    wr(14, 32'hFFFFFFFF); rd("R9", 12); rd("R9", 8);
    wr(14, 32'h80000000); rd("R9", 12); rd("R9", 8);
    // R10 read-only and unlisted
    wr(24, 32'hFFFFFFFF); wr(32, 32'h12345678); wr(17, 32'h1); wr(25, 32'h2); wr(40, 32'h3);
    rd_all("R10"); rd("R10", 17); rd("R10", 25);
    // R11 partial strobes / misaligned
    wr(0, 32'hCAFEF00D, 4'h3); wr(0, 32'hCAFEF00D, 4'hF, 2'b01);
    rd("R11", 0); rd("R11", 0, 4'h1); rd("R11", 32, 4'hF, 2'b10);
    // R12 beyond map, hold
    rd("R12", 33); rd("R12", 200);
    rd("R12", 32);
    repeat (3) @(negedge clk);
    check("R12", rdata, 32'h04020000);
    // R13 same-cycle read and write
    begin
      logic [31:0] old;
      old = model_read(4);
      @(negedge clk);
      we = 1'b1; re = 1'b1; addr = {10'd4, 2'b00}; wdata = 32'h13579BDF;
      @(negedge clk);
      we = 1'b0; re = 1'b0;
      model_write(4, 32'h13579BDF);
      check("R13", rdata, old);
      rd("R13", 4);
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      int w = $urandom_range(0, 36);
      logic [31:0] d = $urandom();
      logic [3:0] s = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      if ($urandom_range(0, 3) == 0) d[31] = 1'b0;
      if ($urandom_range(0, 1) == 1) wr(w, d, s);
      else rd("R6", w, s);
    end
    rd_all("R2");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule